// File: doc/BRIEF.md
# Floating-Point Compare Unit

This unit compares two IEEE-754 binary64 operands and produces a four-bit condition code together with invalid-operation status. Each operand is sorted into one of three kinds: signalling NaN, quiet NaN, or a numeric value. Numeric values include zeros, subnormals and infinities. A select input chooses one of two compare variants. The ordered variant treats any NaN operand as an invalid compare. The unordered variant treats only signalling NaNs as invalid.

A compare starts when the valid input is high while ready is high. One cycle later the unit does three things in the same cycle:

- It loads the condition code into a condition output.
- It writes the condition code into a four-bit class field of a status register.
- It raises a single-cycle done pulse.

The status register also holds:

- the invalid-operation enable bit used by that compare;
- two per-compare flags, which are rebuilt on every compare;
- two sticky copies of those flags;
- a summary invalid bit.

The operand field widths are parameters. The default values give binary64.

Top module: `fcmp_unit`

## Requirements
- R1: The condition code is one-hot. Bit 3 means less than (a < b), bit 2 means greater than, bit 1 means equal, and bit 0 means unordered. Exactly one bit is set after every compare.
- R2: An operand is a NaN when its exponent is all ones and its fraction is nonzero. A NaN is quiet when the top fraction bit is 1 and signalling when that bit is 0. If either operand is any NaN, the condition code is 4'b0001.
- R3: Numeric operands compare by value. Positive zero and negative zero compare equal, and infinities order by their sign like any other value.
- R4: If either operand is a signalling NaN, the per-compare signalling flag (status bit 8) is set in both variants.
- R5: The invalid-compare flag (status bit 9) is set in the ordered variant (ordered_i=1) when an operand is a signalling NaN, but only when the enable input inv_en_i is 0. The enable value used by a compare is shown in status bit 0.
- R6: In the ordered variant, an operand pair with no signalling NaN and at least one quiet NaN sets the invalid-compare flag.
- R7: In the unordered variant (ordered_i=0), quiet NaNs and numeric operands raise neither per-compare flag.
- R8: Both per-compare flags reflect only the latest compare and are cleared before its flags are evaluated.
- R9: The status class field (bits 4:1) is overwritten with the new condition code on each compare.
- R10: The sticky signalling bit (bit 5) and the sticky compare bit (bit 6) each accumulate their per-compare flag by OR. The summary bit (bit 7) is set by any raised invalid flag. Only reset clears these bits.
- R11: Results and done appear exactly one cycle after a compare is accepted. done is high for that single cycle, and the outputs hold while no compare is accepted. Compares may be accepted back to back.
- R12: Synchronous reset clears done, the condition output and the whole status register, and drops ready. Ready is high again on the first cycle after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid_i | input | 1 | Requests a compare |
| start_ready_o | output | 1 | Unit can accept a compare |
| op_a_i | input | 1+EXP_W+FRAC_W | First operand |
| op_b_i | input | 1+EXP_W+FRAC_W | Second operand |
| ordered_i | input | 1 | 1 selects the ordered variant, 0 the unordered variant |
| inv_en_i | input | 1 | Invalid-operation enable bit for this compare |
| done_o | output | 1 | Single-cycle result pulse |
| cond_o | output | 4 | Condition code of the last compare |
| status_o | output | 10 | Status register, bit fields as in R5 and R8 to R10 |

## Verification
The bench builds the unit with a three-bit exponent and a two-bit fraction. Each operand then fits in six bits, and the bench drives every operand pair under both variants and both enable values. That is 16,384 back-to-back compares.

This small format still contains every operand class:

- both zeros;
- subnormals and normals;
- both infinities;
- quiet and signalling NaNs of either sign.

As a result, every ordering corner and every flag rule is exercised exhaustively. Expected results come from decoding each operand into a signed integer scaled value, so the comparison in the bench does not reuse the bit-level ordering of the design. The sticky bits are tracked by a running model across the whole sweep.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        KIND_NUM  = 2'd0,
        KIND_QNAN = 2'd1,
        KIND_SNAN = 2'd2
    } opnd_kind_e;

    localparam int CC_W  = 4;
    localparam int CC_LT = 3;
    localparam int CC_GT = 2;
    localparam int CC_EQ = 1;
    localparam int CC_UN = 0;

    localparam int ST_INV_EN  = 0;
    localparam int ST_CLS_LO  = 1;
    localparam int ST_CLS_HI  = 4;
    localparam int ST_SNAN_SK = 5;
    localparam int ST_VC_SK   = 6;
    localparam int ST_VX_SUM  = 7;
    localparam int ST_OP_SNAN = 8;
    localparam int ST_OP_VC   = 9;
    localparam int ST_W       = 10;

    typedef struct packed {
        logic [CC_W-1:0] cc;
        logic            op_snan;
        logic            op_vc;
    } cmp_result_t;

    function automatic logic [CC_W-1:0] cc_onehot(input int pos);
        logic [CC_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]   opnd_i,
    output opnd_kind_e              kind_o,
    output logic                    sign_o,
    output logic                    zero_o,
    output logic [EXP_W+FRAC_W-1:0] mag_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &opnd_i[W-2:FRAC_W];
        frac_nz  = |opnd_i[FRAC_W-1:0];
        sign_o   = opnd_i[W-1];
        mag_o    = opnd_i[W-2:0];
        zero_o   = ~|opnd_i[W-2:0];
        if (exp_ones && frac_nz)
            kind_o = opnd_i[FRAC_W-1] ? KIND_QNAN : KIND_SNAN;
        else
            kind_o = KIND_NUM;
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int MAG_W = 63
) (
    input  logic             a_sign_i,
    input  logic             a_zero_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             b_sign_i,
    input  logic             b_zero_i,
    input  logic [MAG_W-1:0] b_mag_i,
    output logic             lt_o,
    output logic             gt_o,
    output logic             eq_o
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a_mag_i < b_mag_i;
        mag_eq = a_mag_i == b_mag_i;
        lt_o = 1'b0;
        gt_o = 1'b0;
        eq_o = 1'b0;
        if (a_zero_i && b_zero_i) begin
            eq_o = 1'b1;
        end else if (a_sign_i != b_sign_i) begin
            lt_o = a_sign_i;
            gt_o = b_sign_i;
        end else if (mag_eq) begin
            eq_o = 1'b1;
        end else if (!a_sign_i) begin
            lt_o = mag_lt;
            gt_o = !mag_lt;
        end else begin
            lt_o = !mag_lt;
            gt_o = mag_lt;
        end
    end

endmodule

// File: rtl/fcmp_status.sv
module fcmp_status
    import fcmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_i,
    input  cmp_result_t     res_i,
    input  logic            inv_en_i,
    output logic            done_o,
    output logic [CC_W-1:0] cond_o,
    output logic [ST_W-1:0] status_o
);
    logic            done_q;
    logic [CC_W-1:0] cond_q;
    logic [ST_W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            cond_q <= '0;
            stat_q <= '0;
        end else begin
            done_q <= acc_i;
            if (acc_i) begin
                cond_q                       <= res_i.cc;
                stat_q[ST_CLS_HI:ST_CLS_LO]  <= res_i.cc;
                stat_q[ST_INV_EN]            <= inv_en_i;
                stat_q[ST_OP_SNAN]           <= res_i.op_snan;
                stat_q[ST_OP_VC]             <= res_i.op_vc;
                stat_q[ST_SNAN_SK]           <= stat_q[ST_SNAN_SK] | res_i.op_snan;
                stat_q[ST_VC_SK]             <= stat_q[ST_VC_SK] | res_i.op_vc;
                stat_q[ST_VX_SUM]            <= stat_q[ST_VX_SUM] | res_i.op_snan | res_i.op_vc;
            end
        end
    end

    assign done_o   = done_q;
    assign cond_o   = cond_q;
    assign status_o = stat_q;

    assert_cc_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($countones(cond_q) == 1));

    assert_class_copy_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (stat_q[ST_CLS_HI:ST_CLS_LO] == cond_q));

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$fell(stat_q[ST_SNAN_SK]) && !$fell(stat_q[ST_VC_SK]) && !$fell(stat_q[ST_VX_SUM]));

    assert_sticky_cover_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_q[ST_OP_SNAN] || stat_q[ST_OP_VC]) |-> stat_q[ST_VX_SUM]);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_i |=> $stable(cond_q) && $stable(stat_q));

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_valid_i,
    output logic                   start_ready_o,
    input  logic [EXP_W+FRAC_W:0]  op_a_i,
    input  logic [EXP_W+FRAC_W:0]  op_b_i,
    input  logic                   ordered_i,
    input  logic                   inv_en_i,
    output logic                   done_o,
    output logic [3:0]             cond_o,
    output logic [9:0]             status_o
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int MAG_W = W - 1;

    logic [W-1:0]     opnd   [2];
    opnd_kind_e       kind   [2];
    logic             sgn    [2];
    logic             zro    [2];
    logic [MAG_W-1:0] mag    [2];

    assign opnd[0] = op_a_i;
    assign opnd[1] = op_b_i;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .opnd_i (opnd[i]),
            .kind_o (kind[i]),
            .sign_o (sgn[i]),
            .zero_o (zro[i]),
            .mag_o  (mag[i])
        );
    end

    logic lt, gt, eq;

    fcmp_order #(.MAG_W(MAG_W)) u_ord (
        .a_sign_i (sgn[0]),
        .a_zero_i (zro[0]),
        .a_mag_i  (mag[0]),
        .b_sign_i (sgn[1]),
        .b_zero_i (zro[1]),
        .b_mag_i  (mag[1]),
        .lt_o     (lt),
        .gt_o     (gt),
        .eq_o     (eq)
    );

    logic        rdy_q;
    logic        acc;
    logic        snan_any;
    logic        qnan_any;
    cmp_result_t res;

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b0;
        else     rdy_q <= 1'b1;
    end

    assign acc = start_valid_i && rdy_q;

    always_comb begin
        snan_any    = (kind[0] == KIND_SNAN) || (kind[1] == KIND_SNAN);
        qnan_any    = (kind[0] == KIND_QNAN) || (kind[1] == KIND_QNAN);
        res.op_snan = 1'b0;
        res.op_vc   = 1'b0;
        if (snan_any) begin
            res.op_snan = 1'b1;
            res.op_vc   = ordered_i && !inv_en_i;
            res.cc      = cc_onehot(CC_UN);
        end else if (qnan_any) begin
            res.op_vc   = ordered_i;
            res.cc      = cc_onehot(CC_UN);
        end else if (lt) begin
            res.cc      = cc_onehot(CC_LT);
        end else if (gt) begin
            res.cc      = cc_onehot(CC_GT);
        end else begin
            res.cc      = cc_onehot(CC_EQ);
        end
    end

    fcmp_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .acc_i    (acc),
        .res_i    (res),
        .inv_en_i (inv_en_i),
        .done_o   (done_o),
        .cond_o   (cond_o),
        .status_o (status_o)
    );

    assign start_ready_o = rdy_q;

    assert_order_excl_R3: assert property (@(posedge clk) disable iff (rst)
        $countones({lt, gt, eq}) == 1);

    assert_nan_unordered_R2: assert property (@(posedge clk) disable iff (rst)
        acc |=> (cond_o[CC_UN] == $past(snan_any || qnan_any)));

    assert_snan_flag_R4: assert property (@(posedge clk) disable iff (rst)
        acc |=> (status_o[ST_OP_SNAN] == $past(snan_any)));

    assert_vc_masked_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o[ST_INV_EN] && status_o[ST_OP_SNAN]) |-> !status_o[ST_OP_VC]);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(acc));

endmodule

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;
    localparam int EW = 3;
    localparam int FW = 2;
    localparam int W  = 1 + EW + FW;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_valid = 1'b0;
    logic         start_ready;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         ordered = 1'b0;
    logic         inv_en = 1'b0;
    logic         done;
    logic [3:0]   cond;
    logic [9:0]   status;

    int checks = 0;
    int errors = 0;
    logic sk_snan = 1'b0, sk_vc = 1'b0, sk_sum = 1'b0;

    always #2.5 clk = ~clk;

    fcmp_unit #(.EXP_W(EW), .FRAC_W(FW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .start_valid_i (start_valid),
        .start_ready_o (start_ready),
        .op_a_i        (op_a),
        .op_b_i        (op_b),
        .ordered_i     (ordered),
        .inv_en_i      (inv_en),
        .done_o        (done),
        .cond_o        (cond),
        .status_o      (status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h ord=%0b en=%0b)",
                     req, act, exp, op_a, op_b, ordered, inv_en);
        end
    endtask

    function automatic bit is_nan(logic [W-1:0] x);
        return (x[W-2:FW] == {EW{1'b1}}) && (x[FW-1:0] != 0);
    endfunction

    function automatic bit is_snan(logic [W-1:0] x);
        return is_nan(x) && !x[FW-1];
    endfunction

    function automatic int value_of(logic [W-1:0] x);
        int e, f, m;
        e = int'(x[W-2:FW]);
        f = int'(x[FW-1:0]);
        if (e == (1 << EW) - 1) m = 100000;
        else if (e == 0)        m = f;
        else                    m = ((1 << FW) + f) << (e - 1);
        return x[W-1] ? -m : m;
    endfunction

    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic ord, input logic en);
        int   exp_cc;
        logic e_snan, e_vc, any_snan, any_nan;
        op_a = a; op_b = b; ordered = ord; inv_en = en;
        start_valid = 1'b1;
        any_snan = is_snan(a) || is_snan(b);
        any_nan  = is_nan(a) || is_nan(b);
        e_snan = any_snan;
        e_vc   = any_snan ? (ord && !en) : (any_nan && ord);
        if (any_nan)                       exp_cc = 1;
        else if (value_of(a) < value_of(b)) exp_cc = 8;
        else if (value_of(a) > value_of(b)) exp_cc = 4;
        else                               exp_cc = 2;
        sk_snan = sk_snan | e_snan;
        sk_vc   = sk_vc | e_vc;
        sk_sum  = sk_sum | e_snan | e_vc;
        @(negedge clk);
        chk("R11 done", int'(done), 1);
        chk("R1/R2/R3 cond", int'(cond), exp_cc);
        chk("R9 class field", int'(status[4:1]), exp_cc);
        chk("R4/R8 op snan flag", int'(status[8]), int'(e_snan));
        chk("R5/R6/R7/R8 op compare flag", int'(status[9]), int'(e_vc));
        chk("R5 enable bit", int'(status[0]), int'(en));
        chk("R10 sticky", int'(status[7:5]), int'({sk_sum, sk_vc, sk_snan}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] hold_cond;
        logic [9:0] hold_stat;
        repeat (3) @(negedge clk);
        chk("R12 reset done", int'(done), 0);
        chk("R12 reset cond", int'(cond), 0);
        chk("R12 reset status", int'(status), 0);
        chk("R12 reset ready", int'(start_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 ready after reset", int'(start_ready), 1);
        chk("R11 no done when idle", int'(done), 0);

        // R8: explicit clearing of per-compare flags after a signalling NaN
        run_one(6'b011101, 6'b000100, 1'b1, 1'b0);
        run_one(6'b000100, 6'b000100, 1'b1, 1'b0);
        // R3: signed zeros and infinities
        run_one(6'b100000, 6'b000000, 1'b0, 1'b0);
        run_one(6'b111100, 6'b011100, 1'b1, 1'b1);
        run_one(6'b011100, 6'b011100, 1'b1, 1'b0);

        for (int en = 0; en < 2; en++)
            for (int ord = 0; ord < 2; ord++)
                for (int a = 0; a < (1 << W); a++)
                    for (int b = 0; b < (1 << W); b++)
                        run_one(W'(a), W'(b), ord[0], en[0]);

        // R11: outputs hold and done drops when nothing is accepted
        start_valid = 1'b0;
        hold_cond = cond;
        hold_stat = status;
        op_a = 6'b011110;
        op_b = 6'b000001;
        @(negedge clk);
        chk("R11 done single cycle", int'(done), 0);
        chk("R11 cond hold", int'(cond), int'(hold_cond));
        chk("R11 status hold", int'(status), int'(hold_stat));
        @(negedge clk);
        chk("R11 cond hold later", int'(cond), int'(hold_cond));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule